// File: doc/BRIEF.md
# Flat Page-Table Translation Unit

This block turns a 32-bit device virtual address into a physical address. It uses one flat table of 32-bit descriptors in memory, one descriptor for each 4 KB page. The table covers the full 4 GB virtual space, so it holds 2^20 descriptors and occupies 4 MB.

A client hands over a virtual address and a requester ID. The block then:

- forms the descriptor address from the table base register;
- fetches the descriptor through a memory-read port with a request/valid and response/valid handshake;
- returns the physical address, or a fault response that points at a 128-byte-aligned protect address.

Only one translation is in flight at a time.

Faults are recorded in a small register file that software reaches through a simple read/write port. The record holds status bits, the page address of the faulting access and an encoded requester ID. The first fault after a clear fixes the address and ID fields. Later faults only add status bits until software clears the interrupt. The fault record does not say whether the access was a read or a write.

Top module: `pgxlate_top`

Register map (word index on `reg_addr`):

| Index | Register | Contents |
|---|---|---|
| 0 | Table base | Read/write, 32 bits. |
| 1 | Interrupt control | Enables in bits [7:0]. Bit 12 is write-1-to-clear and reads as 0. |
| 2 | Protect address | Read/write. Bits [6:0] are forced to 0. |
| 3 | Fault status | Read-only, bits [7:0]. |
| 4 | Fault page address | Read-only. |
| 5 | Fault ID | Read-only. Port in bits [3:0], master group in bits [6:4]. |
| 6, 7 | Unused | Read as 0. |

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `mem_req_valid` and `irq` are 0, and every register reads 0.
- R2: An accepted request drives `mem_req_addr` = table base + (VA[31:12] × 4), modulo 2^32, on the next cycle. `mem_req_valid` and the address stay steady until `mem_req_ready` is seen.
- R3: For a descriptor with bit 1 set, `rsp_valid` pulses for one cycle. The pulse comes on the cycle after the memory response. The pulse carries `rsp_pa` = {descriptor[31:12], VA[11:0]}, `rsp_fault` = 0 and `rsp_nonsec` = descriptor bit 3.
- R4: For a descriptor with bit 1 clear (a translation fault), the response has `rsp_fault` = 1 and `rsp_pa` equal to the protect address register. Fault status bit 0 is set.
- R5: A write to the protect address register stores the written value with bits [6:0] forced to 0.
- R6: A memory response with `mem_rsp_err` = 1 (a table-walk fault) gives a fault response to the protect address. It sets fault status bit 4 and does not set bit 0.
- R7: The first fault after a clear captures two records:
  - the fault page address, VA with bits [11:0] cleared;
  - the fault ID, with bits [3:0] = ID[11:8] and bits [6:4] = (6 − ID[15:13]) mod 8.

  Later faults before a clear only OR in status bits. Writes to registers 3 to 5 are ignored.
- R8: `irq` equals the OR of the fault status bits ANDed with the enable bits [7:0] of interrupt control.
- R9: Writing interrupt control with bit 12 set clears the fault status and loads the enables from bits [7:0]. Bit 12 always reads 0. If a fault arrives in the same cycle as the clear, the status holds only the new fault's bit, and the record is recaptured from the new fault.
- R10: `req_ready` is 1 only when no translation is in flight. It falls on the cycle after acceptance and stays low until the response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, can accept a request |
| req_va | input | 32 | Virtual address |
| req_id | input | 16 | Requester ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical or protect address |
| rsp_fault | output | 1 | Response is a fault redirect |
| rsp_nonsec | output | 1 | Page marked non-secure |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Memory read error |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Fault interrupt |

## Verification
A software clear of the interrupt can land on the same clock edge at which the fault logic posts a new fault. Only the new fault should survive that edge.

The bench provokes this by driving the interrupt-control write with bit 12 set at the same edge as the descriptor response of a faulting walk. It does this both while an older record is held and while none is held.

It then reads back status, page address and ID. It expects exactly the new fault's status bit, a record taken from the new request, and `irq` high when that source is enabled.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} walk_state_t;

  localparam int unsigned REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] RA_BASE   = 3'd0;
  localparam logic [REG_IDX_W-1:0] RA_INTCTL = 3'd1;
  localparam logic [REG_IDX_W-1:0] RA_PROT   = 3'd2;
  localparam logic [REG_IDX_W-1:0] RA_STAT   = 3'd3;
  localparam logic [REG_IDX_W-1:0] RA_FVA    = 3'd4;
  localparam logic [REG_IDX_W-1:0] RA_FID    = 3'd5;

  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned SRC_XLAT  = 0;
  localparam int unsigned SRC_WALK  = 4;
  localparam int unsigned CLR_BIT   = 12;
  localparam int unsigned D_VALID   = 1;
  localparam int unsigned D_NONSEC  = 3;
endpackage

// File: rtl/pgx_walk.sv
module pgx_walk #(
  parameter int unsigned AW       = 32,
  parameter int unsigned ID_W     = 16,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  input  logic [ID_W-1:0] req_id,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] prot_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_pa,
  output logic          rsp_fault,
  output logic          rsp_nonsec,
  output logic          flt_xlat,
  output logic          flt_walk,
  output logic [AW-1:0] flt_va,
  output logic [ID_W-1:0] flt_id
);
  import pgx_pkg::*;

  localparam int unsigned VPN_W = AW - PG_SHIFT;

  walk_state_t state;
  logic [AW-1:0]   va_q;
  logic [ID_W-1:0] id_q;
  logic            rsp_here;
  logic            hit;
  logic            unused_desc;

  assign rsp_here      = (state == W_WAIT) && mem_rsp_valid;
  assign hit           = !mem_rsp_err && mem_rsp_data[D_VALID];
  assign flt_xlat      = rsp_here && !mem_rsp_err && !mem_rsp_data[D_VALID];
  assign flt_walk      = rsp_here && mem_rsp_err;
  assign flt_va        = {va_q[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign flt_id        = id_q;
  assign req_ready     = (state == W_IDLE);
  assign mem_req_valid = (state == W_REQ);
  assign unused_desc   = ^mem_rsp_data[PG_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= W_IDLE;
      va_q         <= '0;
      id_q         <= '0;
      mem_req_addr <= '0;
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_fault    <= 1'b0;
      rsp_nonsec   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        W_IDLE: if (req_valid) begin
          va_q         <= req_va;
          id_q         <= req_id;
          mem_req_addr <= tbl_base + AW'({req_va[AW-1:PG_SHIFT], 2'b00});
          state        <= W_REQ;
        end
        W_REQ: if (mem_req_ready) state <= W_WAIT;
        W_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          if (hit) begin
            rsp_pa     <= {mem_rsp_data[AW-1:PG_SHIFT], va_q[PG_SHIFT-1:0]};
            rsp_fault  <= 1'b0;
            rsp_nonsec <= mem_rsp_data[D_NONSEC];
          end else begin
            rsp_pa     <= prot_addr;
            rsp_fault  <= 1'b1;
            rsp_nonsec <= 1'b0;
          end
          state <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  if (VPN_W + 2 > AW) begin : g_bad_width
    $error("page shift too small for descriptor address");
  end
endmodule

// File: rtl/pgx_regs.sv
module pgx_regs #(
  parameter int unsigned AW        = 32,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned PROT_SHFT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            flt_xlat,
  input  logic            flt_walk,
  input  logic [AW-1:0]   flt_va,
  input  logic [ID_W-1:0] flt_id,
  output logic [AW-1:0]   tbl_base,
  output logic [AW-1:0]   prot_addr,
  output logic            irq
);
  import pgx_pkg::*;

  localparam int unsigned GRP_LSB  = ID_W - 3;
  localparam int unsigned PORT_LSB = 8;

  logic [NUM_SRC-1:0] en_q, stat_q, ev, stat_base;
  logic [AW-1:0]      fva_q;
  logic [6:0]         fid_q, fid_enc;
  logic               wr, clr, capture;
  logic               unused_id;

  assign wr        = reg_en && reg_we;
  assign clr       = wr && (reg_addr == RA_INTCTL) && reg_wdata[CLR_BIT];
  assign fid_enc   = {3'd6 - flt_id[GRP_LSB +: 3], flt_id[PORT_LSB +: 4]};
  assign unused_id = ^{flt_id[GRP_LSB-1], flt_id[PORT_LSB-1:0]};

  always_comb begin
    ev           = '0;
    ev[SRC_XLAT] = flt_xlat;
    ev[SRC_WALK] = flt_walk;
    stat_base    = clr ? '0 : stat_q;
    capture      = (|ev) && (stat_base == '0);
  end

  assign irq = |(stat_q & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_base  <= '0;
      prot_addr <= '0;
      en_q      <= '0;
      stat_q    <= '0;
      fva_q     <= '0;
      fid_q     <= '0;
      reg_rdata <= '0;
    end else begin
      stat_q <= stat_base | ev;
      if (capture) begin
        fva_q <= flt_va;
        fid_q <= fid_enc;
      end
      if (wr) begin
        unique case (reg_addr)
          RA_BASE:   tbl_base  <= reg_wdata;
          RA_INTCTL: en_q      <= reg_wdata[NUM_SRC-1:0];
          RA_PROT:   prot_addr <= {reg_wdata[AW-1:PROT_SHFT], {PROT_SHFT{1'b0}}};
          default: ;
        endcase
      end
      if (reg_en && !reg_we) begin
        unique case (reg_addr)
          RA_BASE:   reg_rdata <= tbl_base;
          RA_INTCTL: reg_rdata <= AW'(en_q);
          RA_PROT:   reg_rdata <= prot_addr;
          RA_STAT:   reg_rdata <= AW'(stat_q);
          RA_FVA:    reg_rdata <= fva_q;
          RA_FID:    reg_rdata <= AW'(fid_q);
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgxlate_top.sv
module pgxlate_top #(
  parameter int unsigned AW        = 32,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned PG_SHIFT  = 12,
  parameter int unsigned PROT_SHFT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_va,
  input  logic [ID_W-1:0] req_id,
  output logic            rsp_valid,
  output logic [AW-1:0]   rsp_pa,
  output logic            rsp_fault,
  output logic            rsp_nonsec,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [AW-1:0]   mem_rsp_data,
  input  logic            mem_rsp_err,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  output logic            irq
);
  logic [AW-1:0]   tbl_base, prot_addr, flt_va;
  logic [ID_W-1:0] flt_id;
  logic            flt_xlat, flt_walk;

  pgx_walk #(.AW(AW), .ID_W(ID_W), .PG_SHIFT(PG_SHIFT)) u_walk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_id(req_id),
    .tbl_base(tbl_base), .prot_addr(prot_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
    .flt_xlat(flt_xlat), .flt_walk(flt_walk), .flt_va(flt_va), .flt_id(flt_id)
  );

  pgx_regs #(.AW(AW), .ID_W(ID_W), .PROT_SHFT(PROT_SHFT)) u_regs (
    .clk(clk), .rst(rst),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_xlat(flt_xlat), .flt_walk(flt_walk), .flt_va(flt_va), .flt_id(flt_id),
    .tbl_base(tbl_base), .prot_addr(prot_addr), .irq(irq)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [6:0]    rsp_pa_lo,
  input logic          reg_en,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          clr_bit,
  input logic          irq
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready); // R10

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3

  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(mem_rsp_valid)); // R3

  AST_PROT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pa_lo == 7'd0)); // R5

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_en && reg_we && reg_addr == 3'd1 && clr_bit && !mem_rsp_valid) |=> !irq); // R9
endmodule

bind pgxlate_top pgx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_pa_lo(rsp_pa[6:0]), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .clr_bit(reg_wdata[12]), .irq(irq)
);

// File: tb/sim_pgxlate_top.sv
`timescale 1ns/1ps
module sim_pgxlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic [15:0] req_id = '0;
  logic        rsp_valid, rsp_fault, rsp_nonsec;
  logic [31:0] rsp_pa;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] base_m = '0, prot_m = '0;
  logic [7:0]  en_m = '0, stat_m = '0;
  logic [31:0] fva_m = '0;
  logic [6:0]  fid_m = '0;

  always #5 clk = ~clk;

  pgxlate_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_of(input logic [19:0] vpn);
    logic [19:0] ppn = vpn * 20'd5 + 20'h31;
    return {ppn, 8'hA5, vpn[1], 1'b0, (vpn % 4) != 3, 1'b1};
  endfunction

  function automatic logic err_of(input logic [19:0] vpn);
    return (vpn % 13) == 7;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(posedge clk); #1 reg_en = 0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [15:0] id,
                       input int rdy_dly, input int rsp_dly, input bit do_clr);
    logic [19:0] vpn = va[31:12];
    logic [31:0] d = desc_of(vpn);
    logic e = err_of(vpn);
    logic [7:0] ev;
    @(negedge clk); req_valid = 1; req_va = va; req_id = id;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk("R10 busy", {31'd0, req_ready}, 32'd0);
    chk("R2 addr", mem_req_addr, base_m + {10'd0, vpn, 2'b00});
    for (int k = 0; k < rdy_dly; k++) @(negedge clk);
    chk("R2 hold", {31'd0, mem_req_valid}, 32'd1);
    mem_req_ready = 1;
    @(posedge clk); #1 mem_req_ready = 0;
    for (int k = 0; k < rsp_dly; k++) @(negedge clk);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = d; mem_rsp_err = e;
    if (do_clr) begin reg_en = 1; reg_we = 1; reg_addr = 3'd1; reg_wdata = {19'd0, 1'b1, 4'd0, en_m}; end
    @(posedge clk); #1 mem_rsp_valid = 0; reg_en = 0; reg_we = 0;
    @(negedge clk);
    chk("R3 valid", {31'd0, rsp_valid}, 32'd1);
    ev = '0;
    if (e) begin
      chk("R6 fault", {31'd0, rsp_fault}, 32'd1);
      chk("R6 pa", rsp_pa, prot_m);
      ev[4] = 1;
    end else if (!d[1]) begin
      chk("R4 fault", {31'd0, rsp_fault}, 32'd1);
      chk("R4 pa", rsp_pa, prot_m);
      ev[0] = 1;
    end else begin
      chk("R3 fault", {31'd0, rsp_fault}, 32'd0);
      chk("R3 pa", rsp_pa, {d[31:12], va[11:0]});
      chk("R3 nonsec", {31'd0, rsp_nonsec}, {31'd0, d[3]});
    end
    if (do_clr) stat_m = '0;
    if (ev != 0 && stat_m == 0) begin
      fva_m = {va[31:12], 12'd0};
      fid_m = {3'd6 - id[15:13], id[11:8]};
    end
    stat_m |= ev;
    chk("R8 irq", {31'd0, irq}, {31'd0, |(stat_m & en_m)});
  endtask

  task automatic check_record(input string tag);
    logic [31:0] v;
    rd(3'd3, v); chk({tag, " R7 status"}, v, {24'd0, stat_m});
    rd(3'd4, v); chk({tag, " R7 fva"}, v, fva_m);
    rd(3'd5, v); chk({tag, " R7 fid"}, v, {25'd0, fid_m});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); chk("R1 reg", v, 32'd0);
    end
    // R5 protect alignment
    wr(3'd2, 32'h1234_56FF); prot_m = 32'h1234_5680;
    rd(3'd2, v); chk("R5 prot", v, prot_m);
    base_m = 32'h0040_0000; wr(3'd0, base_m);
    rd(3'd0, v); chk("R2 base", v, base_m);
    en_m = 8'h11; wr(3'd1, 32'h11);
    rd(3'd1, v); chk("R9 intctl", v, 32'h11);
    // main sweep
    for (int i = 0; i < 52; i++) begin
      logic [19:0] vpn = 20'(i * 37 + 1);
      logic [31:0] va = {vpn, 12'(i * 97)};
      logic [15:0] id = 16'(i * 16'h2351);
      if (i == 26) begin en_m = 8'h01; wr(3'd1, 32'h01); end
      xlate(va, id, i % 3, i % 4, (i % 5) == 4);
      if (i % 7 == 6) begin
        wr(3'd1, {19'd0, 1'b1, 4'd0, en_m}); stat_m = '0;
        @(negedge clk); chk("R9 irq cleared", {31'd0, irq}, 32'd0);
        rd(3'd1, v); chk("R9 clr reads 0", v, {24'd0, en_m});
      end
      check_record("sweep");
    end
    // R7 read-only registers ignore writes
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    check_record("ro");
    // R9 collision: fault in same cycle as clear, with old record held
    en_m = 8'h11; wr(3'd1, 32'h1000 | 32'h11); stat_m = '0;
    xlate({20'd3, 12'h111}, 16'h7A00, 0, 0, 0);        // fault, captures
    xlate({20'd7, 12'h222}, 16'hE300, 1, 1, 1);        // walk error + clear
    check_record("collide");
    chk("R9 collide status", {24'd0, stat_m}, 32'h10);
    // R2 wrap of descriptor address
    base_m = 32'hFFFF_F000; wr(3'd0, base_m);
    xlate({20'h00800, 12'h004}, 16'h0100, 2, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule